// File: doc/BRIEF.md
# Crosspoint Routing Control Registers

This block holds the routing state for a switch matrix with eight inputs and four outputs. A parallel write port carries an output address and a four-bit code. The code either names the input that the addressed output should carry or turns that output off. Each output owns two registers. A staging register takes the written code. A live register drives the output's input select and its enable pins.

A separate hold pin sets when the live registers take new values. While the pin is low, the live registers follow the staging registers, so each write reaches its output a few clocks later. While the pin is high, the live registers keep their value, and firmware can restage any number of outputs without a glitch. When the pin falls, every staged change takes effect on the same clock edge. The write strobe, chip enable and hold pin are asynchronous. Each passes through a two-flop synchroniser, and a write is registered once for each assertion of the strobe.

Top module: `xpt_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, every output has oe = 0 and sel = 0, until a write changes that output.
- R2: A staging register is written only while wr_n and ce_n are both low. A strobe with either pin held high leaves every output unchanged.
- R3: A write changes only the output numbered by addr (0 to 3). The other outputs keep their routing.
- R4: A code with data[3] = 0 routes input data[2:0] (0 to 7) to the addressed output and sets its oe to 1.
- R5: A code with data[3] = 1 sets oe = 0 and sel = 0 on the addressed output, whatever data[2:0] holds.
- R6: While upd is low, a write appears on sel and oe within five clocks of the strobe being asserted.
- R7: While upd is high, sel and oe do not change, even when staging registers are written.
- R8: When upd falls, all staged changes appear on sel and oe in the same clock cycle. No mix of old and new routing is ever visible.
- R9: One assertion of the strobe performs one write. A change on addr or data while the strobe stays low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Asynchronous write strobe, active low |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| upd | input | 1 | Asynchronous hold for the live registers: high holds, low follows |
| addr | input | 2 | Output number for the write |
| data | input | 4 | Bit 3 disables the output; bits 2:0 give the input index |
| sel | output | 4x3 | Input index driven to each output |
| oe | output | 4 | Output enable for each output |

## Verification
The bench stages several outputs while upd is high and watches each clock after upd falls. A design that loaded the live registers one by one, or that let a write pass straight through the hold, would show a cycle with mixed old and new routing. It sends strobes with only one of the two enables low, which a design that decodes just wr_n would accept. It changes the data while the strobe stays low, which a level-triggered write would capture. It writes disable codes whose low bits are not zero, which catches a design that leaves the stale index on sel or takes oe from the wrong bit.

// File: rtl/xpt_pkg.sv
// Package: default sizes shared by the crosspoint control blocks.
// Assumes a power-of-two count of outputs and inputs.
package xpt_pkg;
    localparam int DEF_NUM_OUT = 4;
    localparam int DEF_NUM_IN  = 8;
endpackage

// File: rtl/xpt_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous pins.
// Assumes each bit is a level signal that needs no coherence with the others.
module xpt_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Purpose: two register stages, loaded with the idle level during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xpt_wr_detect.sv
// Turns the synchronised write strobe and chip enable into a one-cycle write event.
// Assumes both inputs are already synchronised and active low.
module xpt_wr_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_s_n,
    input  logic ce_s_n,
    output logic evt
);
    logic active;
    logic active_q;

    // Purpose: the strobe counts only when both pins are low.
    always_comb active = !wr_s_n && !ce_s_n;

    // Purpose: remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    // Purpose: a single event at the start of each strobe assertion.
    always_comb evt = active && !active_q;
endmodule

// File: rtl/xpt_input_bank.sv
// Staging registers, one for each output, written by the addressed write event.
// Assumes addr and data are stable from before the strobe until the event.
module xpt_input_bank #(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 3,
    localparam int ADDR_W = $clog2(NUM_OUT),
    localparam int DATA_W = SEL_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           evt,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              data,
    output logic [NUM_OUT-1:0]             en,
    output logic [NUM_OUT-1:0][SEL_W-1:0]  idx
);
    logic             off_code;
    logic [SEL_W-1:0] idx_code;

    // Purpose: decode the code: top bit disables, and a disabled entry stores index 0.
    always_comb begin
        off_code = data[DATA_W-1];
        idx_code = off_code ? '0 : data[SEL_W-1:0];
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_stage
        // Purpose: load this entry when the event addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[i]  <= 1'b0;
                idx[i] <= '0;
            end else if (evt && (addr == ADDR_W'(i))) begin
                en[i]  <= !off_code;
                idx[i] <= idx_code;
            end
        end
    end
endmodule

// File: rtl/xpt_switch_bank.sv
// Live routing registers: follow the staging bank while hold is low, freeze while it is high.
// Assumes hold is synchronised, so all entries load on the same edge.
module xpt_switch_bank #(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hold,
    input  logic [NUM_OUT-1:0]             in_en,
    input  logic [NUM_OUT-1:0][SEL_W-1:0]  in_idx,
    output logic [NUM_OUT-1:0]             en,
    output logic [NUM_OUT-1:0][SEL_W-1:0]  idx
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_live
        // Purpose: copy the staged entry on every clock that hold is low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[i]  <= 1'b0;
                idx[i] <= '0;
            end else if (!hold) begin
                en[i]  <= in_en[i];
                idx[i] <= in_idx[i];
            end
        end
    end
endmodule

// File: rtl/xpt_ctrl.sv
// Top of the crosspoint control: synchronises the control pins, stages writes
// and updates the routing of all outputs together.
// Assumes addr and data are held stable while the strobe is being synchronised.
module xpt_ctrl #(
    parameter int  NUM_OUT = xpt_pkg::DEF_NUM_OUT,
    parameter int  NUM_IN  = xpt_pkg::DEF_NUM_IN,
    localparam int ADDR_W  = $clog2(NUM_OUT),
    localparam int SEL_W   = $clog2(NUM_IN),
    localparam int DATA_W  = SEL_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_n,
    input  logic                           ce_n,
    input  logic                           upd,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              data,
    output logic [NUM_OUT-1:0][SEL_W-1:0]  sel,
    output logic [NUM_OUT-1:0]             oe
);
    logic                          wr_s_n;
    logic                          ce_s_n;
    logic                          upd_s;
    logic                          wr_evt;
    logic [NUM_OUT-1:0]            in_en;
    logic [NUM_OUT-1:0][SEL_W-1:0] in_idx;

    xpt_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({upd, ce_n, wr_n}),
        .q     ({upd_s, ce_s_n, wr_s_n})
    );

    xpt_wr_detect u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_s_n (wr_s_n),
        .ce_s_n (ce_s_n),
        .evt    (wr_evt)
    );

    xpt_input_bank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (wr_evt),
        .addr  (addr),
        .data  (data),
        .en    (in_en),
        .idx   (in_idx)
    );

    xpt_switch_bank #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (upd_s),
        .in_en  (in_en),
        .in_idx (in_idx),
        .en     (oe),
        .idx    (sel)
    );
endmodule

// File: rtl/xpt_ctrl_chk.sv
// Checker for xpt_ctrl: relates the staging bank, the live outputs and the
// synchronised control events over time. Attached by bind below.
module xpt_ctrl_chk #(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           upd_s,
    input logic                           wr_evt,
    input logic [ADDR_W-1:0]              wr_addr,
    input logic [NUM_OUT-1:0]             in_en,
    input logic [NUM_OUT-1:0][SEL_W-1:0]  in_idx,
    input logic [NUM_OUT-1:0]             oe,
    input logic [NUM_OUT-1:0][SEL_W-1:0]  sel
);
    // R2: staging changes only after a write event
    a_r2_stage_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_evt) |-> ($stable(in_en) && $stable(in_idx)));

    // R6: with hold low the live bank takes the staged values
    a_r6_follow_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!upd_s) |-> ((oe == $past(in_en)) && (sel == $past(in_idx))));

    // R7: with hold high the outputs are frozen
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(upd_s) |-> ($stable(oe) && $stable(sel)));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
        // R5: a disabled output shows index zero
        a_r5_off_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !oe[i] |-> (sel[i] == '0));

        // R3: a write to another address leaves this entry alone
        a_r3_other_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_evt) && ($past(wr_addr) != ADDR_W'(i)))
                |-> ($stable(in_en[i]) && $stable(in_idx[i])));
    end
endmodule

bind xpt_ctrl xpt_ctrl_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_s   (upd_s),
    .wr_evt  (wr_evt),
    .wr_addr (addr),
    .in_en   (in_en),
    .in_idx  (in_idx),
    .oe      (oe),
    .sel     (sel)
);

// File: tb/xpt_ctrl_bench.sv
module xpt_ctrl_bench;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_n = 1'b1;
    logic            ce_n = 1'b1;
    logic            upd = 1'b0;
    logic [1:0]      addr = '0;
    logic [3:0]      data = '0;
    logic [3:0][2:0] sel;
    logic [3:0]      oe;

    logic [3:0][2:0] m_sel;
    logic [3:0]      m_oe;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // {addr[1:0], data[3:0], expected oe, expected sel[2:0]}
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 4'b0101, 1'b1, 3'd5},
        {2'd1, 4'b0111, 1'b1, 3'd7},
        {2'd2, 4'b0000, 1'b1, 3'd0},
        {2'd3, 4'b0011, 1'b1, 3'd3},
        {2'd1, 4'b1110, 1'b0, 3'd0},
        {2'd0, 4'b0010, 1'b1, 3'd2},
        {2'd3, 4'b1000, 1'b0, 3'd0},
        {2'd2, 4'b0110, 1'b1, 3'd6}
    };

    always #4 clk = ~clk;

    xpt_ctrl u_xpt_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .ce_n(ce_n), .upd(upd),
        .addr(addr), .data(data), .sel(sel), .oe(oe)
    );

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected fewer", cyc);
            report();
        end
    end

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_out(string req);
        checks++;
        if (oe !== m_oe || sel !== m_sel) begin
            errors++;
            $display("FAIL %s: actual oe=%b sel=%h expected oe=%b sel=%h",
                     req, oe, sel, m_oe, m_sel);
        end
    endtask

    task automatic strobe(logic [1:0] a, logic [3:0] d, logic w, logic c);
        @(negedge clk);
        addr = a; data = d;
        wr_n = w; ce_n = c;
        wait_clk(5);
        wr_n = 1'b1; ce_n = 1'b1;
        wait_clk(5);
    endtask

    task automatic set_upd(logic v);
        @(negedge clk);
        upd = v;
        wait_clk(5);
    endtask

    initial begin
        wait_clk(3);
        m_oe = '0; m_sel = '0;
        check_out("R1 during reset");
        rst_n = 1'b1;
        wait_clk(3);
        check_out("R1 after reset");

        // Table walk, hold low: each write lands on its own output only
        for (int k = 0; k < 8; k++) begin
            strobe(VEC[k][9:8], VEC[k][7:4], 1'b0, 1'b0);
            m_oe[VEC[k][9:8]]  = VEC[k][3];
            m_sel[VEC[k][9:8]] = VEC[k][2:0];
            check_out("R3 R4 R5 R6 table");
        end

        // R2: only one of the two enables low
        strobe(2'd0, 4'b0001, 1'b0, 1'b1);
        check_out("R2 ce_n high");
        strobe(2'd0, 4'b0001, 1'b1, 1'b0);
        check_out("R2 wr_n high");

        // R5: disable code with nonzero low bits
        strobe(2'd2, 4'b1111, 1'b0, 1'b0);
        m_oe[2] = 1'b0; m_sel[2] = 3'd0;
        check_out("R5 disable with 111");

        // R9: data changes while strobe stays low
        @(negedge clk);
        addr = 2'd1; data = 4'b0100;
        wr_n = 1'b0; ce_n = 1'b0;
        wait_clk(6);
        addr = 2'd3; data = 4'b0001;
        wait_clk(6);
        wr_n = 1'b1; ce_n = 1'b1;
        wait_clk(5);
        m_oe[1] = 1'b1; m_sel[1] = 3'd4;
        check_out("R9 single write per strobe");

        // R7: hold high, stage three outputs
        set_upd(1'b1);
        strobe(2'd0, 4'b0111, 1'b0, 1'b0);
        check_out("R7 hold after first write");
        strobe(2'd2, 4'b0011, 1'b0, 1'b0);
        strobe(2'd3, 4'b0101, 1'b0, 1'b0);
        wait_clk(4);
        check_out("R7 hold after three writes");

        // R8: release, outputs must switch all at once
        begin
            logic [3:0][2:0] new_sel;
            logic [3:0]      new_oe;
            logic [3:0][2:0] old_sel;
            logic [3:0]      old_oe;
            bit mixed = 0;
            old_sel = m_sel; old_oe = m_oe;
            new_sel = m_sel; new_oe = m_oe;
            new_oe[0] = 1'b1; new_sel[0] = 3'd7;
            new_oe[2] = 1'b1; new_sel[2] = 3'd3;
            new_oe[3] = 1'b1; new_sel[3] = 3'd5;
            @(negedge clk);
            upd = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (!((oe === old_oe && sel === old_sel) ||
                      (oe === new_oe && sel === new_sel))) mixed = 1;
            end
            checks++;
            if (mixed) begin
                errors++;
                $display("FAIL R8 mixed routing seen: actual mixed=1 expected mixed=0");
            end
            m_oe = new_oe; m_sel = new_sel;
            check_out("R8 all staged changes applied");
        end

        // R6 again after release: a plain write follows
        strobe(2'd3, 4'b0000, 1'b0, 1'b0);
        m_oe[3] = 1'b1; m_sel[3] = 3'd0;
        check_out("R6 follow after release");

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(2);
        m_oe = '0; m_sel = '0;
        check_out("R1 reset clears live routing");
        rst_n = 1'b1;
        wait_clk(3);
        check_out("R1 cleared after release");

        done = 1;
        report();
    end
endmodule